// File: doc/BRIEF.md
# Flag-Chained Integer Add/Subtract Unit

This unit computes one of five integer add or subtract operations on two operands in a single combinational pass. It keeps a one-bit flag register, T, that is written at a clock edge. Depending on the operation, the flag acts as a carry-in, a borrow-in or an overflow report. The caller supplies the flag value it wants consumed on `t_in`, usually the registered `t_out` looped back. This lets several narrow operations chain into a wider add or subtract. Negation takes a borrow and produces one, so a multi-word value can be negated word by word.

The operand width is a parameter (default 32). The data interface is a plain strobe. The unit never applies back-pressure: every cycle with `valid` high is accepted, and the flag is written at the next rising edge. `result` is combinational and follows the inputs within the same cycle.

Top module: `cou_unit`

## Requirements
- R1: Code 0 (add with carry) gives result = a + b + t_in modulo 2^WIDTH. The flag becomes the carry out of that sum, taken at bit WIDTH.
- R2: Code 1 (add with overflow check) gives result = a + b. The flag becomes 1 only when a and b have equal sign bits (bit WIDTH-1) and the result's sign bit differs from theirs. Otherwise it becomes 0.
- R3: Code 2 (subtract with borrow) gives result = b - a - t_in modulo 2^WIDTH. The flag becomes 1 when the exact difference is negative.
- R4: Code 3 (subtract with overflow check) gives result = b - a. The flag becomes 1 only when the sign bits of a and b differ and the result's sign bit differs from b's. Otherwise it becomes 0.
- R5: Code 4 (negate with borrow) gives result = 0 - a - t_in modulo 2^WIDTH. The flag becomes 1 when a is nonzero or t_in is 1.
- R6: Codes 5, 6 and 7 drive result to zero and leave the flag unchanged even when valid is high.
- R7: The flag changes only at a rising clock edge where valid is high. With valid low it holds its value.
- R8: Reset (rst_n low, asynchronous) clears the flag to 0.
- R9: A 2*WIDTH-bit add is produced by first clearing the flag (code 1 with a = b = 0), then issuing code 0 on the low words and code 0 on the high words back to back, with t_out fed to t_in. The two results and the final flag form the full sum.
- R10: result depends only on the current inputs. The flag written by an operation appears on t_out after the rising edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation strobe; flag is written when high |
| op | input | 3 | Operation code (0..4 active, 5..7 reserved) |
| a | input | WIDTH | First operand (subtrahend for subtracts and negate) |
| b | input | WIDTH | Second operand (minuend for subtracts) |
| t_in | input | 1 | Flag value consumed as carry or borrow in |
| result | output | WIDTH | Combinational result |
| t_out | output | 1 | Registered flag |

## Verification
The bench builds the unit with WIDTH = 4. With that width it can sweep every operation code against every pair of operands and both flag inputs, a few thousand vectors. This covers every carry, borrow and sign-overflow corner exactly, including the most negative value and zero. The same small width lets the chained test form 8-bit sums from two 4-bit steps over a broad grid of operand pairs. Each result is compared with plain integer arithmetic.

// File: rtl/cou_pkg.sv
package cou_pkg;
  localparam logic [2:0] OP_ADDC = 3'd0;
  localparam logic [2:0] OP_ADDV = 3'd1;
  localparam logic [2:0] OP_SUBC = 3'd2;
  localparam logic [2:0] OP_SUBV = 3'd3;
  localparam logic [2:0] OP_NEGC = 3'd4;

  typedef struct packed {
    logic legal;    // code 0..4
    logic sub;      // subtract path
    logic use_ovf;  // flag takes signed overflow instead of carry/borrow
    logic use_cin;  // t_in participates
    logic zero_x;   // minuend forced to zero (negate)
  } cou_ctl_t;
endpackage

// File: rtl/cou_decode.sv
module cou_decode
  import cou_pkg::*;
(
  input  logic [2:0] op,
  output cou_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (op)
      OP_ADDC: begin ctl.legal = 1'b1; ctl.use_cin = 1'b1; end
      OP_ADDV: begin ctl.legal = 1'b1; ctl.use_ovf = 1'b1; end
      OP_SUBC: begin ctl.legal = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; end
      OP_SUBV: begin ctl.legal = 1'b1; ctl.sub = 1'b1; ctl.use_ovf = 1'b1; end
      OP_NEGC: begin
        ctl.legal = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; ctl.zero_x = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/cou_addsub.sv
module cou_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] xe, ye, ce, ext;

  always_comb begin
    xe  = {1'b0, x};
    ye  = {1'b0, y};
    ce  = {{WIDTH{1'b0}}, cin};
    ext = sub ? (xe - ye - ce) : (xe + ye + ce);
    sum  = ext[MSB:0];
    cout = ext[WIDTH];  // carry for add, borrow for subtract
    if (sub) ovf = (x[MSB] != y[MSB]) && (ext[MSB] != x[MSB]);
    else     ovf = (x[MSB] == y[MSB]) && (ext[MSB] != x[MSB]);
  end
endmodule

// File: rtl/cou_tflag.sv
module cou_tflag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cou_unit.sv
module cou_unit
  import cou_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             t_in,
  output logic [WIDTH-1:0] result,
  output logic             t_out
);
  cou_ctl_t         ctl;
  logic [WIDTH-1:0] x_opnd, y_opnd, sum;
  logic             cin, cout, ovf, t_next;

  cou_decode u_dec (.op(op), .ctl(ctl));

  always_comb begin
    x_opnd = ctl.zero_x ? '0 : (ctl.sub ? b : a);
    y_opnd = ctl.sub ? a : b;
    cin    = ctl.use_cin & t_in;
  end

  cou_addsub #(.WIDTH(WIDTH)) u_as (
    .x(x_opnd), .y(y_opnd), .sub(ctl.sub), .cin(cin),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  always_comb begin
    result = ctl.legal ? sum : '0;
    t_next = ctl.use_ovf ? ovf : cout;
  end

  cou_tflag u_flag (
    .clk(clk), .rst_n(rst_n), .load(valid & ctl.legal), .d(t_next), .q(t_out)
  );
endmodule

// File: rtl/cou_unit_chk.sv
module cou_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             t_in,
  input logic [WIDTH-1:0] result,
  input logic             t_out
);
  assert_reset_clear_R8: assert property (@(posedge clk) !rst_n |=> !t_out);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(t_out));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 3'd4) |-> (result == '0));

  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op > 3'd4) |=> $stable(t_out));

  assert_carry_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0) |-> (result == WIDTH'(a + b + WIDTH'(t_in))));

  assert_no_add_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd1 && a[WIDTH-1] != b[WIDTH-1]) |=> !t_out);

  assert_no_sub_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd3 && a[WIDTH-1] == b[WIDTH-1]) |=> !t_out);

  assert_neg_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd4 && (a != '0 || t_in)) |=> t_out);
endmodule

bind cou_unit cou_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .b(b),
  .t_in(t_in), .result(result), .t_out(t_out)
);

// File: tb/sim_cou_unit.sv
`timescale 1ns/1ps
module sim_cou_unit;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         t_in = 1'b0;
  logic [W-1:0] result;
  logic         t_out;

  int checks = 0;
  int errors = 0;
  logic exp_t = 1'b0;

  always #4 clk = ~clk;

  cou_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .b(b),
    .t_in(t_in), .result(result), .t_out(t_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reference model: returns {flag, result}
  function automatic int model(input int o, input int x, input int y, input int t, input int prev);
    int s, r, tn, sx, sy, sr;
    sx = (x >> (W-1)) & 1;
    sy = (y >> (W-1)) & 1;
    case (o)
      0: begin s = x + y + t; r = s & M; tn = (s >> W) & 1; end
      1: begin s = x + y; r = s & M; sr = (r >> (W-1)) & 1;
               tn = (sx == sy && sr != sx) ? 1 : 0; end
      2: begin s = y - x - t; r = s & M; tn = (s < 0) ? 1 : 0; end
      3: begin s = y - x; r = s & M; sr = (r >> (W-1)) & 1;
               tn = (sx != sy && sr != sy) ? 1 : 0; end
      4: begin s = 0 - x - t; r = s & M; tn = (s < 0) ? 1 : 0; end
      default: begin r = 0; tn = prev; end
    endcase
    return (tn << W) | r;
  endfunction

  task automatic issue(input int o, input int x, input int y, input int t, input bit v,
                       output int res_seen);
    int m;
    @(negedge clk);
    op = 3'(o); a = W'(x); b = W'(y); t_in = t[0]; valid = v;
    #1;
    m = model(o, x, y, t, int'(exp_t));
    res_seen = int'(result);
    check({tag(o), " result (R10)"}, int'(result), m & M);
    if (v) exp_t = m[W];
    @(posedge clk); #1;
    check({tag(o), " flag"}, int'(t_out), int'(exp_t));
    valid = 1'b0;
  endtask

  initial begin : watchdog
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int r, lo, hi, cy;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset flag", int'(t_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // Exhaustive sweep of all codes, operands and flag inputs
    for (int o = 0; o < 8; o++)
      for (int x = 0; x <= M; x++)
        for (int y = 0; y <= M; y++)
          for (int t = 0; t < 2; t++)
            issue(o, x, y, t, 1'b1, r);

    // R7: valid low must not touch the flag
    issue(4, 5, 0, 0, 1'b1, r);          // flag -> 1
    issue(1, 0, 0, 0, 1'b0, r);          // would clear, but idle
    check("R7 hold while idle", int'(t_out), 1);
    issue(1, 0, 0, 0, 1'b1, r);          // flag -> 0
    issue(4, 3, 0, 1, 1'b0, r);          // would set, but idle
    check("R7 hold while idle", int'(t_out), 0);

    // R6: reserved code with the flag set keeps it set
    issue(0, M, 1, 0, 1'b1, r);          // carry -> 1
    issue(6, M, M, 1, 1'b1, r);
    check("R6 reserved keeps flag", int'(t_out), 1);

    // R9: chained double-width add
    for (int x = 0; x < 256; x += 7)
      for (int y = 0; y < 256; y += 11) begin
        issue(1, 0, 0, 0, 1'b1, r);
        issue(0, x & M, y & M, int'(t_out), 1'b1, lo);
        issue(0, (x >> W) & M, (y >> W) & M, int'(t_out), 1'b1, hi);
        cy = int'(t_out);
        check("R9 chained sum", (cy << (2*W)) | (hi << W) | lo, x + y);
      end

    // R8: asynchronous reset clears a set flag
    issue(4, 1, 0, 0, 1'b1, r);
    #1 rst_n = 1'b0; #1;
    check("R8 async clear", int'(t_out), 0);
    exp_t = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule